// File: doc/BRIEF.md
# Lockable SMI Enable Register

This block stores a 32-bit SMI enable register behind an I/O write port and a 16-bit power-management control word behind a configuration-space port. A per-bit write mask guards the SMI enable register: a write at I/O offset 0 changes only the bits the mask allows. After reset the mask is all ones.

The control word carries a lock bit. When software writes a 1 to the lock bit, the global SMI enable bit (bit 0 of the SMI enable register) leaves the write mask. The lock bit also stops accepting writes. Both conditions persist until the next reset. Both registers can be read back. The block also drives the global SMI enable level as an output.

Firmware sets the global enable, sets the lock, and from then on no later software can change whether SMIs are globally enabled.

Top module: `smi_lock_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, the SMI enable register resets to zero, except bit 5 (APMC enable), which takes the value of `smm_enable`. The control word resets to zero and every SMI enable bit becomes writable.
- R2: A write with `io_wr` high and `io_addr` equal to 0 sets the SMI enable register to (old AND NOT mask) OR (data AND mask). Writes to any other I/O offset change nothing.
- R3: The control word sits in the low 16 bits of configuration dword index 0x28 (byte offset 0xA0), and its bit 4 is the lock bit. Configuration writes to other dword indices leave the control word unchanged.
- R4: Byte enable bit i covers `cfg_wdata[8i+7:8i]`. Only enabled bytes of the control word change.
- R5: A configuration write that leaves the lock bit at 1 and has at least one byte enable set, to dword 0x28 or 0x29 (bytes 0xA0–0xA7), removes bit 0 from the write mask from the next cycle on. After that, bit 0 of the SMI enable register ignores writes while the other bits stay writable.
- R6: While the lock bit is 1, writes cannot clear it. The other control-word bits stay writable.
- R7: Only reset clears the lock bit and returns bit 0 to the write mask.
- R8: `io_rdata` holds the SMI enable register in the cycle after `io_addr` = 0 is presented, and 0 for other offsets. `cfg_rdata` holds {16'h0, control word} in the cycle after `cfg_addr` = 0x28 is presented, and 0 otherwise. Reads have no side effects.
- R9: `gbl_smi_en` equals bit 0 of the SMI enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smm_enable | input | 1 | Sets the APMC enable reset value |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 4 | I/O register offset |
| io_wdata | input | 32 | I/O write data |
| io_rdata | output | 32 | Registered I/O read data |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Configuration byte enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered configuration read data |
| gbl_smi_en | output | 1 | Global SMI enable level |

## Verification
The bench sets the lock and then writes to bit 0 with both polarities. A design that keeps bit 0 in the mask would let the global enable change. A design that freezes the whole register would stop the upper bits from changing. The bench writes zero over the lock bit, and a design without the self-seal would read back a cleared lock. Partial byte-enable writes and writes to neighbouring dwords are checked so that a mis-decoded byte lane or address shows up in the read-back. Reset with `smm_enable` high must release the lock and restore the APMC default, and a design that kept lock state through reset would leave bit 0 frozen.

// File: rtl/smi_lock_pkg.sv
package smi_lock_pkg;
    localparam int SMI_W_DEF      = 32;
    localparam int PMCON_W_DEF    = 16;
    localparam int CFG_DW_DEF     = 32;
    localparam int CFG_AW_DEF     = 6;
    localparam int IO_AW_DEF      = 4;
    localparam int LOCK_BIT_DEF   = 4;
    localparam int APMC_BIT_DEF   = 5;
    localparam int GBL_BIT_DEF    = 0;
    localparam int PMCON_DW_IDX   = 'h28;
    localparam int LOCK_SPAN_DW   = 2;

    typedef struct packed {
        logic [CFG_DW_DEF-1:0] io;
        logic [CFG_DW_DEF-1:0] cfg;
    } rd_regs_t;
endpackage

// File: rtl/smi_lock_cfg.sv
module smi_lock_cfg #(
    parameter int PMCON_W  = 16,
    parameter int CFG_DW   = 32,
    parameter int CFG_AW   = 6,
    parameter int LOCK_BIT = 4,
    parameter int PM_IDX   = 'h28,
    parameter int SPAN_DW  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW/8-1:0] cfg_be,
    input  logic [PMCON_W-1:0] cfg_wdata,
    output logic [PMCON_W-1:0] pmcon,
    output logic              lock_apply
);
    localparam int PM_BYTES = PMCON_W / 8;

    logic [PMCON_W-1:0] pmcon_d, pmcon_q;
    logic [PMCON_W-1:0] lane_mask;
    logic [PMCON_W-1:0] bit_wmask;
    logic               hit;
    logic               overlap;

    always_comb begin
        for (int i = 0; i < PMCON_W; i++) begin
            lane_mask[i] = cfg_be[i / 8];
        end
        bit_wmask           = '1;
        bit_wmask[LOCK_BIT] = ~pmcon_q[LOCK_BIT];
        hit     = cfg_wr && (cfg_addr == CFG_AW'(PM_IDX)) && (|cfg_be[PM_BYTES-1:0]);
        overlap = 1'b0;
        for (int k = 0; k < SPAN_DW; k++) begin
            if (cfg_addr == CFG_AW'(PM_IDX + k)) overlap = 1'b1;
        end
        overlap = overlap && cfg_wr && (|cfg_be);
        pmcon_d = pmcon_q;
        if (hit) begin
            pmcon_d = (pmcon_q & ~(lane_mask & bit_wmask))
                    | (cfg_wdata & lane_mask & bit_wmask);
        end
        if (!rst_n) pmcon_d = '0;
        lock_apply = rst_n && overlap && pmcon_d[LOCK_BIT];
    end

    always_ff @(posedge clk) begin
        pmcon_q <= pmcon_d;
    end

    assign pmcon = pmcon_q;
endmodule

// File: rtl/smi_en_store.sv
module smi_en_store #(
    parameter int SMI_W    = 32,
    parameter int IO_AW    = 4,
    parameter int APMC_BIT = 5,
    parameter int GBL_BIT  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smm_enable,
    input  logic             io_wr,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [SMI_W-1:0] io_wdata,
    input  logic             lock_apply,
    output logic [SMI_W-1:0] smi_en
);
    typedef struct packed {
        logic [SMI_W-1:0] en;
        logic [SMI_W-1:0] wm;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (io_wr && (io_addr == '0)) begin
            st_d.en = (st_q.en & ~st_q.wm) | (io_wdata & st_q.wm);
        end
        if (lock_apply) begin
            st_d.wm[GBL_BIT] = 1'b0;
        end
        if (!rst_n) begin
            st_d.en           = '0;
            st_d.en[APMC_BIT] = smm_enable;
            st_d.wm           = '1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign smi_en = st_q.en;
endmodule

// File: rtl/smi_lock_regs.sv
module smi_lock_regs
    import smi_lock_pkg::*;
#(
    parameter int SMI_W    = SMI_W_DEF,
    parameter int PMCON_W  = PMCON_W_DEF,
    parameter int CFG_DW   = CFG_DW_DEF,
    parameter int CFG_AW   = CFG_AW_DEF,
    parameter int IO_AW    = IO_AW_DEF,
    parameter int LOCK_BIT = LOCK_BIT_DEF,
    parameter int APMC_BIT = APMC_BIT_DEF,
    parameter int GBL_BIT  = GBL_BIT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smm_enable,
    input  logic              io_wr,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [SMI_W-1:0]  io_wdata,
    output logic [SMI_W-1:0]  io_rdata,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW/8-1:0] cfg_be,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    output logic              gbl_smi_en
);
    logic [PMCON_W-1:0] pmcon_w;
    logic [SMI_W-1:0]   smi_en_w;
    logic               lock_apply_w;
    logic               unused_hi;
    rd_regs_t           rd_d, rd_q;

    assign unused_hi = ^cfg_wdata[CFG_DW-1:PMCON_W];

    smi_lock_cfg #(
        .PMCON_W(PMCON_W), .CFG_DW(CFG_DW), .CFG_AW(CFG_AW),
        .LOCK_BIT(LOCK_BIT), .PM_IDX(PMCON_DW_IDX), .SPAN_DW(LOCK_SPAN_DW)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata[PMCON_W-1:0]),
        .pmcon(pmcon_w), .lock_apply(lock_apply_w)
    );

    smi_en_store #(
        .SMI_W(SMI_W), .IO_AW(IO_AW), .APMC_BIT(APMC_BIT), .GBL_BIT(GBL_BIT)
    ) u_en (
        .clk(clk), .rst_n(rst_n), .smm_enable(smm_enable), .io_wr(io_wr),
        .io_addr(io_addr), .io_wdata(io_wdata), .lock_apply(lock_apply_w),
        .smi_en(smi_en_w)
    );

    always_comb begin
        rd_d     = '0;
        rd_d.io  = (io_addr == '0) ? CFG_DW_DEF'(smi_en_w) : '0;
        rd_d.cfg = (cfg_addr == CFG_AW'(PMCON_DW_IDX)) ? CFG_DW_DEF'(pmcon_w) : '0;
        if (!rst_n) rd_d = '0;
    end

    always_ff @(posedge clk) begin
        rd_q <= rd_d;
    end

    assign io_rdata   = SMI_W'(rd_q.io);
    assign cfg_rdata  = CFG_DW'(rd_q.cfg);
    assign gbl_smi_en = smi_en_w[GBL_BIT];
endmodule

// File: rtl/smi_lock_chk.sv
module smi_lock_chk #(
    parameter int SMI_W    = 32,
    parameter int PMCON_W  = 16,
    parameter int IO_AW    = 4,
    parameter int LOCK_BIT = 4,
    parameter int GBL_BIT  = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             io_wr,
    input logic [IO_AW-1:0] io_addr,
    input logic [SMI_W-1:0] io_wdata,
    input logic [SMI_W-1:0] smi_en,
    input logic [PMCON_W-1:0] pmcon,
    input logic             gbl_smi_en
);
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        pmcon[LOCK_BIT] |=> pmcon[LOCK_BIT]);                                  // R6
    AST_GBL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        pmcon[LOCK_BIT] |=> $stable(smi_en[GBL_BIT]));                         // R5
    AST_OPEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pmcon[LOCK_BIT] && io_wr && io_addr == '0) |=> smi_en == $past(io_wdata)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr == '0) |=> $stable(smi_en));                        // R2
    AST_GBL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == '0 && !pmcon[LOCK_BIT]) |=> gbl_smi_en == $past(io_wdata[GBL_BIT])); // R9
endmodule

bind smi_lock_regs smi_lock_chk u_chk (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .smi_en(smi_en_w), .pmcon(pmcon_w),
    .gbl_smi_en(gbl_smi_en)
);

// File: tb/smi_lock_regs_bench.sv
`timescale 1ns/100ps
module smi_lock_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smm_enable = 1'b0;
    logic        io_wr = 1'b0;
    logic [3:0]  io_addr = '0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        gbl_smi_en;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    smi_lock_regs u_smi_lock_regs (
        .clk(clk), .rst_n(rst_n), .smm_enable(smm_enable),
        .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .gbl_smi_en(gbl_smi_en)
    );

    // kind: 0 io write, 1 cfg write, 2 io read check, 3 cfg read check
    typedef struct packed {
        logic [1:0]  kind;
        logic [5:0]  addr;
        logic [3:0]  be;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{2'd2, 6'h00, 4'h0, 32'h0,          32'h0000_0000, 4'd1}, // R1
        '{2'd3, 6'h28, 4'h0, 32'h0,          32'h0000_0000, 4'd1}, // R1
        '{2'd0, 6'h00, 4'h0, 32'hFFFF_FFFF,  32'h0,         4'd2},
        '{2'd2, 6'h00, 4'h0, 32'h0,          32'hFFFF_FFFF, 4'd2}, // R2 all bits writable
        '{2'd0, 6'h01, 4'h0, 32'h0,          32'h0,         4'd2},
        '{2'd2, 6'h00, 4'h0, 32'h0,          32'hFFFF_FFFF, 4'd2}, // R2 other offset ignored
        '{2'd2, 6'h01, 4'h0, 32'h0,          32'h0000_0000, 4'd8}, // R8
        '{2'd0, 6'h00, 4'h0, 32'h0000_1234,  32'h0,         4'd2},
        '{2'd2, 6'h00, 4'h0, 32'h0,          32'h0000_1234, 4'd2},
        '{2'd1, 6'h28, 4'h2, 32'h0000_AB00,  32'h0,         4'd4},
        '{2'd3, 6'h28, 4'h0, 32'h0,          32'h0000_AB00, 4'd4}, // R4 upper byte only
        '{2'd1, 6'h28, 4'h1, 32'h0000_00EF,  32'h0,         4'd4},
        '{2'd3, 6'h28, 4'h0, 32'h0,          32'h0000_ABEF, 4'd4},
        '{2'd1, 6'h28, 4'hC, 32'hFFFF_FFFF,  32'h0,         4'd4},
        '{2'd3, 6'h28, 4'h0, 32'h0,          32'h0000_ABEF, 4'd4}, // R4 bytes 2,3 not stored
        '{2'd1, 6'h2A, 4'hF, 32'hFFFF_FFFF,  32'h0,         4'd3},
        '{2'd3, 6'h28, 4'h0, 32'h0,          32'h0000_ABEF, 4'd3}, // R3 other dword
        '{2'd3, 6'h2A, 4'h0, 32'h0,          32'h0000_0000, 4'd8}, // R8
        '{2'd1, 6'h28, 4'h3, 32'h0,          32'h0,         4'd4},
        '{2'd0, 6'h00, 4'h0, 32'hFFFF_FFFE,  32'h0,         4'd2},
        '{2'd2, 6'h00, 4'h0, 32'h0,          32'hFFFF_FFFE, 4'd2}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk); io_wr = 1'b0;
    endtask

    task automatic cfg_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic io_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); io_addr = a;
        @(negedge clk); d = io_rdata;
    endtask

    task automatic cfg_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); cfg_addr = a;
        @(negedge clk); d = cfg_rdata;
    endtask

    task automatic do_reset(input logic smm);
        @(negedge clk); rst_n = 1'b0; smm_enable = smm;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    logic [31:0] rv;

    initial begin : main
        do_reset(1'b0);
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].kind)
                2'd0: io_write(VEC[i].addr[3:0], VEC[i].data);
                2'd1: cfg_write(VEC[i].addr, VEC[i].be, VEC[i].data);
                2'd2: begin
                    io_read(VEC[i].addr[3:0], rv);
                    check($sformatf("R%0d vec%0d", VEC[i].req, i), rv, VEC[i].exp);
                end
                default: begin
                    cfg_read(VEC[i].addr, rv);
                    check($sformatf("R%0d vec%0d", VEC[i].req, i), rv, VEC[i].exp);
                end
            endcase
        end
        check("R9 gbl low", {31'b0, gbl_smi_en}, 32'h0);

        // R3 R5: set lock with global enable at 0
        cfg_write(6'h28, 4'h1, 32'h0000_0010);
        cfg_read(6'h28, rv);  check("R3 lock bit set", rv, 32'h0000_0010);
        io_write(4'h0, 32'h0000_0001);
        io_read(4'h0, rv);    check("R5 gbl frozen at 0", rv, 32'h0000_0000);
        io_write(4'h0, 32'hFFFF_FFFF);
        io_read(4'h0, rv);    check("R5 others writable", rv, 32'hFFFF_FFFE);
        check("R9 gbl stays low", {31'b0, gbl_smi_en}, 32'h0);
        // R6: lock cannot be cleared, other bits still writable
        cfg_write(6'h28, 4'h3, 32'h0000_C300);
        cfg_read(6'h28, rv);  check("R6 self-seal", rv, 32'h0000_C310);
        cfg_write(6'h29, 4'hF, 32'h0);
        io_write(4'h0, 32'h0000_0001);
        io_read(4'h0, rv);    check("R5 after 0x29 write", rv, 32'h0000_0000);

        // R1 with smm_enable; R7 reset clears the lock
        do_reset(1'b1);
        io_read(4'h0, rv);    check("R1 apmc default", rv, 32'h0000_0020);
        cfg_read(6'h28, rv);  check("R7 lock cleared", rv, 32'h0000_0000);
        io_write(4'h0, 32'h0000_0021);
        check("R9 gbl high", {31'b0, gbl_smi_en}, 32'h1);
        io_read(4'h0, rv);    check("R7 bit0 writable again", rv, 32'h0000_0021);
        cfg_write(6'h28, 4'h1, 32'h0000_0010);
        io_write(4'h0, 32'h0000_0000);
        io_read(4'h0, rv);    check("R5 gbl frozen at 1", rv, 32'h0000_0001);
        check("R9 gbl held", {31'b0, gbl_smi_en}, 32'h1);
        io_read(4'h0, rv);    check("R8 read no side effect", rv, 32'h0000_0001);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule